// File: doc/BRIEF.md
# System Reset Control Register

This block is a single-byte reset control register that sits on a byte-wide I/O bus at port 0xCF9. Software writes it for one of two reasons. The first is to pick the kind of system reset that a later trigger should request. The second is to fire that request.

Setting the trigger bit in a write raises a one-cycle request toward the system reset logic and leaves the register as it was. Any other write keeps only the reset-type bit and clears every other bit. A read at the port returns the stored byte. A status flag tells save/restore logic whether the register holds anything other than its reset value. The reset sequencing that acts on the request sits outside this block.

Top module: `sys_rst_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises with no write, the stored value is 0x00, sys_rst_req_o is 0 and nondefault_o is 0.
- R2: A write at address 0xCF9 with data bit 2 clear stores the write data masked to bit 1. Bit 1 holds the reset type, and bits 7..3, 2 and 0 always read back as zero.
- R3: A write at address 0xCF9 with data bit 2 set drives sys_rst_req_o high for exactly the one cycle after the clock edge that samples the write. The request is high only in that case.
- R4: A write that sets data bit 2 leaves the stored value unchanged, whatever data bit 1 holds.
- R5: While io_rd_i is high and io_addr_i is 0xCF9, io_rdata_o shows the stored value in the same cycle.
- R6: An access at any address other than 0xCF9 leaves the stored value unchanged, raises no request and drives io_rdata_o to zero.
- R7: io_rdata_o is zero whenever io_rd_i is low.
- R8: nondefault_o is high exactly when the stored value is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | Write strobe, one access per cycle it is high |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, zero when the block is not selected for a read |
| sys_rst_req_o | output | 1 | System reset request pulse |
| nondefault_o | output | 1 | High while the stored value differs from the reset value |

## Verification
The hardest situation to reach from the ports is a triggering write that also carries bit 1 while the register already holds a different type value. A correct design must change neither the stored byte nor the flag. The stimulus first stores a type of 0x02 and then triggers with 0x04. It then clears the register and triggers with 0xFF. Each trigger is followed by a read. Back-to-back triggering writes and writes to neighbouring addresses 0xCF8 and 0xCFA show that the request tracks each qualifying write cycle and nothing else.

// File: rtl/sys_rst_ctrl_pkg.sv
package sys_rst_ctrl_pkg;
  typedef struct packed {
    logic wr_hit;   // write to our port
    logic rd_hit;   // read of our port
    logic trig;     // write carries the reset trigger
  } rcr_acc_t;
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
  import sys_rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned TRIG_BIT = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rcr_acc_t          acc_o
);
  localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;

  logic sel;
  assign sel          = (addr_i == PORT_ADDR);
  assign acc_o.wr_hit = sel & wr_i;
  assign acc_o.rd_hit = sel & rd_i;
  assign acc_o.trig   = |(wdata_i & TRIG_MASK);
endmodule

// File: rtl/rcr_store.sv
module rcr_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o
);
  // only the reset-type bit is retained
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

  logic [DATA_W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_q <= '0;
    else if (load_i) value_q <= wdata_i & KEEP_MASK;
  end

  assign value_o = value_q;
endmodule

// File: rtl/rcr_pulse.sv
module rcr_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= fire_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
  import sys_rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned TRIG_BIT = 2,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              sys_rst_req_o,
  output logic              nondefault_o
);
  rcr_acc_t          acc;
  logic [DATA_W-1:0] stored;

  rcr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .TRIG_BIT(TRIG_BIT)
  ) u_dec (
    .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .wdata_i(io_wdata_i), .acc_o(acc)
  );

  // trigger writes are self-acting and never reach the register
  rcr_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(acc.wr_hit & ~acc.trig),
    .wdata_i(io_wdata_i), .value_o(stored)
  );

  rcr_pulse u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(acc.wr_hit & acc.trig), .req_o(sys_rst_req_o)
  );

  assign io_rdata_o   = acc.rd_hit ? stored : '0;
  assign nondefault_o = |stored;
endmodule

// File: rtl/sys_rst_ctrl_chk.sv
module sys_rst_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int unsigned TRIG_BIT = 2,
  parameter int unsigned TYPE_BIT = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic [DATA_W-1:0] io_rdata_o,
  input logic              sys_rst_req_o,
  input logic              nondefault_o,
  input logic [DATA_W-1:0] stored
);
  logic hit_w, trig_w;
  assign hit_w  = io_wr_i && (io_addr_i == PORT_ADDR);
  assign trig_w = io_wdata_i[TRIG_BIT];

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (stored == '0 && !sys_rst_req_o && !nondefault_o));

  a_r2_store_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && !trig_w) |=> stored == ($past(io_wdata_i) & (DATA_W'(1) << TYPE_BIT)));

  a_r3_req_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && trig_w) |=> sys_rst_req_o);

  a_r3_req_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_w && trig_w) |=> !sys_rst_req_o);

  a_r4_trig_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w && trig_w) |=> $stable(stored));

  a_r6_no_touch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_w |=> $stable(stored));

  a_r5_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == PORT_ADDR) |-> io_rdata_o == stored);

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || io_addr_i != PORT_ADDR) |-> io_rdata_o == '0);

  a_r8_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nondefault_o == (stored != '0));
endmodule

bind sys_rst_ctrl sys_rst_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
  .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
  .io_rd_i(io_rd_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
  .sys_rst_req_o(sys_rst_req_o), .nondefault_o(nondefault_o), .stored(stored)
);

// File: tb/sim_sys_rst_ctrl.sv
module sim_sys_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        req;
  logic        flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_store = 0;
  int m_req = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_rst_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .sys_rst_req_o(req), .nondefault_o(flag)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, check just before the rising edge, then step the model
  task automatic cyc(input string tag, input logic [15:0] a, input logic w,
                     input logic r, input logic [7:0] d);
    int exp_rd;
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    #(CLK_PERIOD/2 - 1);
    exp_rd = (r && a == PORT) ? m_store : 0;
    check(tag, "rdata", int'(rdata), exp_rd);
    check(tag, "req", int'(req), m_req);
    check("R8", "flag", int'(flag), int'(m_store != 0));
    @(posedge clk);
    m_req = 0;
    if (w && a == PORT) begin
      if (d[2]) m_req = 1;
      else      m_store = int'(d) & 2;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 during and after reset
    cyc("R1", PORT, 1'b0, 1'b1, 8'h00);
    cyc("R1", PORT, 1'b0, 1'b1, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", PORT, 1'b0, 1'b1, 8'h00);

    // R2 masking of stored data
    cyc("R2", PORT, 1'b1, 1'b0, 8'hFB);
    cyc("R5", PORT, 1'b0, 1'b1, 8'h00);
    cyc("R2", PORT, 1'b1, 1'b0, 8'h09);
    cyc("R5", PORT, 1'b0, 1'b1, 8'h00);
    cyc("R2", PORT, 1'b1, 1'b0, 8'h02);

    // R3/R4 trigger keeps stored value and pulses once
    cyc("R4", PORT, 1'b1, 1'b0, 8'h04);
    cyc("R3", PORT, 1'b0, 1'b1, 8'h00);
    cyc("R3", PORT, 1'b0, 1'b0, 8'h00);
    cyc("R2", PORT, 1'b1, 1'b0, 8'h00);
    cyc("R4", PORT, 1'b1, 1'b0, 8'hFF);
    cyc("R4", PORT, 1'b0, 1'b1, 8'h00);

    // R3 back-to-back triggers
    cyc("R3", PORT, 1'b1, 1'b0, 8'h06);
    cyc("R3", PORT, 1'b1, 1'b0, 8'h04);
    cyc("R3", PORT, 1'b0, 1'b1, 8'h00);
    cyc("R3", PORT, 1'b0, 1'b0, 8'h00);

    // R6 neighbouring addresses
    cyc("R2", PORT, 1'b1, 1'b0, 8'h02);
    cyc("R6", 16'hCF8, 1'b1, 1'b1, 8'h04);
    cyc("R6", 16'hCFA, 1'b1, 1'b1, 8'h00);
    cyc("R6", 16'h0CF9 ^ 16'h1000, 1'b1, 1'b1, 8'h00);
    cyc("R5", PORT, 1'b0, 1'b1, 8'h00);

    // R7 no read strobe
    cyc("R7", PORT, 1'b0, 1'b0, 8'h00);
    // read and write in one cycle: read shows the old value
    cyc("R5", PORT, 1'b1, 1'b1, 8'h00);
    cyc("R5", PORT, 1'b0, 1'b1, 8'h00);

    // sweep of data values
    for (int i = 0; i < 256; i += 7) begin
      cyc("R2", PORT, 1'b1, 1'b0, 8'(i));
      cyc("R5", PORT, 1'b0, 1'b1, 8'h00);
    end

    // R1 again with a non-default value held
    cyc("R2", PORT, 1'b1, 1'b0, 8'h02);
    @(negedge clk); rst_n = 1'b0; m_store = 0; m_req = 0;
    cyc("R1", PORT, 1'b0, 1'b1, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", PORT, 1'b0, 1'b1, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule